// File: doc/BRIEF.md
# Bus Cycle Master with Ready-Driven Wait States

This block runs single bus cycles on the processor side of a legacy parallel expansion bus. A local requester presents one memory or I/O access with its direction, address and write data. While the block is idle it takes the request and runs a fixed sequence of phases:

- one address phase, in which the address latch strobe is high;
- two command phases, in which the read or write strobe is high;
- an end phase, which completes the cycle.

The block drives the address, a memory-versus-I/O select line and the command strobes. The target sees them and answers through a ready line.

A fast target leaves ready high, and the cycle completes at strobe speed with no handshake cost. A slow target pulls ready low before the edge that closes the second command phase. Each edge that samples ready low adds one wait phase, up to a fixed ceiling. If ready is still low when the ceiling is reached, the cycle ends anyway and a timeout flag is raised together with the done pulse.

Read data is registered at the edge that ends the last command phase and is held for the requester. Memory accesses use the full address width. I/O accesses use a narrower space, and the address bits above it are forced to zero.

Top module: `busCycleMaster`

## Requirements
- R1: During and after reset, busy, done, timeout, busAle, busRd and busWr are all low until a request is accepted.
- R2: A request seen with reqValid high at a clock edge while idle is accepted. In the next cycle busAle is high for exactly one cycle, and the cycle after that asserts the command strobe.
- R3: busMemSel is 1 for a memory access (reqIo=0), and busAddr then carries all MEM_ADDR_W bits of reqAddr. busMemSel is 0 for an I/O access (reqIo=1), and busAddr then carries reqAddr[IO_ADDR_W-1:0] with every bit above it zero.
- R4: If busReady is high at the edge ending the second command cycle, the command is asserted for exactly two cycles. In that case done is high in the fourth cycle after the accepting edge.
- R5: Each edge that closes a command cycle (from the second one on) and sees busReady low adds one wait cycle. The command strobe and the done pulse are delayed by one cycle for each wait.
- R6: No more than MAX_WAIT wait cycles are inserted. If busReady is still low at the edge that ends the last allowed wait, the cycle ends with timeout high in the same cycle as done. Otherwise timeout is low at done.
- R7: For a read, rdData holds the busRdata value sampled at the edge that ends the last command cycle, from the done cycle until the next read completes. A write leaves rdData unchanged.
- R8: busRd is high only in read cycles and busWr only in write cycles, never both at once. busAddr and busWdata stay stable from the address cycle through the done cycle.
- R9: busy is high from the cycle after acceptance through the done cycle. reqValid is ignored while busy, so neither the running cycle nor busAddr changes.
- R10: done is a one-cycle pulse. In the done cycle both command strobes are low, and busy is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqAddr | input | MEM_ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Wait ceiling reached with ready still low (valid with done) |
| rdData | output | DATA_W | Last read data |
| busAddr | output | MEM_ADDR_W | Bus address |
| busAle | output | 1 | Address latch strobe |
| busRd | output | 1 | Read command strobe |
| busWr | output | 1 | Write command strobe |
| busMemSel | output | 1 | 1 = memory access, 0 = I/O access |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data from the target |
| busReady | input | 1 | Target ready; low stretches the cycle |

## Verification
The bench keeps the default MEM_ADDR_W=20, IO_ADDR_W=16 and MAX_WAIT=6, and widens DATA_W to 16. The bench's target model holds ready low for 0 to 9 sampling edges. This reaches zero waits, every intermediate wait count, exactly the ceiling without a timeout, and one or more edges past the ceiling with a timeout. I/O requests are given addresses with the upper bits set, so the zeroing of the bits above the 16-bit space shows at the bus.

// File: rtl/busCyclePkg.sv
package busCyclePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_C1,
    ST_C2,
    ST_WAIT,
    ST_END
  } cycleState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic captureRd;
  } dpCtrl_t;

endpackage

// File: rtl/busCycleCtrl.sv
module busCycleCtrl
  import busCyclePkg::*;
#(
  parameter int MAX_WAIT = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    busReady,
  output dpCtrl_t dpCtrl,
  output logic    ale,
  output logic    cmdActive,
  output logic    busy,
  output logic    done,
  output logic    timeout
);

  localparam int WAIT_CNT_W = $clog2(MAX_WAIT + 2);
  localparam logic [WAIT_CNT_W-1:0] WAIT_LIMIT = WAIT_CNT_W'(MAX_WAIT);

  cycleState_t stateQ;
  logic [WAIT_CNT_W-1:0] waitCntQ;
  logic timedOutQ;
  logic sampling;
  logic limitHit;

  // C2 and WAIT share one sampling point and one ceiling compare
  assign sampling = (stateQ == ST_C2) || (stateQ == ST_WAIT);
  assign limitHit = (waitCntQ == WAIT_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      waitCntQ  <= '0;
      timedOutQ <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (reqValid) begin
          stateQ    <= ST_T1;
          timedOutQ <= 1'b0;
        end
        ST_T1: stateQ <= ST_C1;
        ST_C1: begin
          stateQ   <= ST_C2;
          waitCntQ <= '0;
        end
        ST_C2, ST_WAIT: begin
          if (busReady) begin
            stateQ <= ST_END;
          end else if (limitHit) begin
            stateQ    <= ST_END;
            timedOutQ <= 1'b1;
          end else begin
            stateQ   <= ST_WAIT;
            waitCntQ <= waitCntQ + 1'b1;
          end
        end
        ST_END: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl.loadReq   = (stateQ == ST_IDLE) && reqValid;
    dpCtrl.captureRd = sampling && (busReady || limitHit);
  end

  assign ale       = (stateQ == ST_T1);
  assign cmdActive = (stateQ == ST_C1) || sampling;
  assign busy      = (stateQ != ST_IDLE);
  assign done      = (stateQ == ST_END);
  assign timeout   = (stateQ == ST_END) && timedOutQ;

endmodule

// File: rtl/busCycleDpath.sv
module busCycleDpath
  import busCyclePkg::*;
#(
  parameter int MEM_ADDR_W = 20,
  parameter int IO_ADDR_W  = 16,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               dpCtrl,
  input  logic                  reqWrite,
  input  logic                  reqIo,
  input  logic [MEM_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     busRdata,
  output logic [MEM_ADDR_W-1:0] addrOut,
  output logic                  memSel,
  output logic                  isWrite,
  output logic [DATA_W-1:0]     wdataOut,
  output logic [DATA_W-1:0]     rdataOut
);

  logic [MEM_ADDR_W-1:0] addrQ;
  logic [MEM_ADDR_W-1:0] addrNext;
  logic memSelQ;
  logic writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  // narrower I/O space: upper bits forced to zero at capture
  generate
    if (IO_ADDR_W < MEM_ADDR_W) begin : g_ioNarrow
      assign addrNext = reqIo ? {{(MEM_ADDR_W-IO_ADDR_W){1'b0}}, reqAddr[IO_ADDR_W-1:0]}
                              : reqAddr;
    end else begin : g_ioFull
      assign addrNext = reqAddr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      memSelQ <= 1'b0;
      writeQ  <= 1'b0;
      wdataQ  <= '0;
      rdataQ  <= '0;
    end else begin
      if (dpCtrl.loadReq) begin
        addrQ   <= addrNext;
        memSelQ <= !reqIo;
        writeQ  <= reqWrite;
        wdataQ  <= reqWdata;
      end
      if (dpCtrl.captureRd && !writeQ) rdataQ <= busRdata;
    end
  end

  assign addrOut  = addrQ;
  assign memSel   = memSelQ;
  assign isWrite  = writeQ;
  assign wdataOut = wdataQ;
  assign rdataOut = rdataQ;

endmodule

// File: rtl/busCycleMaster.sv
module busCycleMaster
  import busCyclePkg::*;
#(
  parameter int MEM_ADDR_W = 20,
  parameter int IO_ADDR_W  = 16,
  parameter int DATA_W     = 8,
  parameter int MAX_WAIT   = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqIo,
  input  logic [MEM_ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic                  busy,
  output logic                  done,
  output logic                  timeout,
  output logic [DATA_W-1:0]     rdData,
  output logic [MEM_ADDR_W-1:0] busAddr,
  output logic                  busAle,
  output logic                  busRd,
  output logic                  busWr,
  output logic                  busMemSel,
  output logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W-1:0]     busRdata,
  input  logic                  busReady
);

  dpCtrl_t dpCtrl;
  logic cmdActive;
  logic isWrite;

  busCycleCtrl #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .busReady  (busReady),
    .dpCtrl    (dpCtrl),
    .ale       (busAle),
    .cmdActive (cmdActive),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout)
  );

  busCycleDpath #(
    .MEM_ADDR_W (MEM_ADDR_W),
    .IO_ADDR_W  (IO_ADDR_W),
    .DATA_W     (DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .reqWrite (reqWrite),
    .reqIo    (reqIo),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .addrOut  (busAddr),
    .memSel   (busMemSel),
    .isWrite  (isWrite),
    .wdataOut (busWdata),
    .rdataOut (rdData)
  );

  assign busRd = cmdActive && !isWrite;
  assign busWr = cmdActive && isWrite;

endmodule

// File: rtl/busCycleChecker.sv
module busCycleChecker #(
  parameter int MEM_ADDR_W = 20,
  parameter int IO_ADDR_W  = 16,
  parameter int DATA_W     = 8,
  parameter int MAX_WAIT   = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busy,
  input logic                  done,
  input logic                  timeout,
  input logic [MEM_ADDR_W-1:0] busAddr,
  input logic                  busAle,
  input logic                  busRd,
  input logic                  busWr,
  input logic                  busMemSel,
  input logic [DATA_W-1:0]     busWdata
);

  int cmdLen;

  always_ff @(posedge clk) begin
    if (!rstN) cmdLen <= 0;
    else if (busRd || busWr) cmdLen <= cmdLen + 1;
    else cmdLen <= 0;
  end

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> !busAle && (busRd || busWr));

  p_io_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !busMemSel) |-> ((busAddr >> IO_ADDR_W) == '0));

  p_wait_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> (cmdLen <= MAX_WAIT + 1));

  p_timeout_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> done);

  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  p_bus_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(busAddr) && $stable(busWdata) && $stable(busMemSel)));

  p_busy_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  p_done_no_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busRd && !busWr && busy));

endmodule

bind busCycleMaster busCycleChecker #(
  .MEM_ADDR_W (MEM_ADDR_W),
  .IO_ADDR_W  (IO_ADDR_W),
  .DATA_W     (DATA_W),
  .MAX_WAIT   (MAX_WAIT)
) u_busCycleChecker (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .busAddr   (busAddr),
  .busAle    (busAle),
  .busRd     (busRd),
  .busWr     (busWr),
  .busMemSel (busMemSel),
  .busWdata  (busWdata)
);

// File: tb/test_busCycleMaster.sv
`timescale 1ns/1ps
module test_busCycleMaster;

  localparam int MEM_ADDR_W = 20;
  localparam int IO_ADDR_W  = 16;
  localparam int DATA_W     = 16;
  localparam int MAX_WAIT   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic reqIo = 1'b0;
  logic [MEM_ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic busy, done, timeout;
  logic [DATA_W-1:0] rdData;
  logic [MEM_ADDR_W-1:0] busAddr;
  logic busAle, busRd, busWr, busMemSel;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata = '0;
  logic busReady = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int tgtLow = 0;
  int cmdSeen = 0;
  logic [DATA_W-1:0] lastRead = '0;

  always #4 clk = ~clk;

  busCycleMaster #(
    .MEM_ADDR_W (MEM_ADDR_W),
    .IO_ADDR_W  (IO_ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_WAIT   (MAX_WAIT)
  ) i_busCycleMaster (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqWrite (reqWrite),
    .reqIo (reqIo), .reqAddr (reqAddr), .reqWdata (reqWdata), .busy (busy),
    .done (done), .timeout (timeout), .rdData (rdData), .busAddr (busAddr),
    .busAle (busAle), .busRd (busRd), .busWr (busWr), .busMemSel (busMemSel),
    .busWdata (busWdata), .busRdata (busRdata), .busReady (busReady)
  );

  // target model: ready low for the first tgtLow sampling edges
  always @(negedge clk) begin
    if (busRd || busWr) begin
      cmdSeen = cmdSeen + 1;
      busReady = (cmdSeen < 2) ? 1'b1 : ((cmdSeen - 2) >= tgtLow);
    end else begin
      cmdSeen = 0;
      busReady = 1'b1;
    end
  end

  function automatic int expWaits(int low);
    return (low > MAX_WAIT) ? MAX_WAIT : low;
  endfunction

  function automatic bit expTimeout(int low);
    return low > MAX_WAIT;
  endfunction

  function automatic logic [MEM_ADDR_W-1:0] expAddr(bit io, logic [MEM_ADDR_W-1:0] a);
    return io ? MEM_ADDR_W'(a[IO_ADDR_W-1:0]) : a;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCycle(bit wr, bit io, logic [MEM_ADDR_W-1:0] addr,
                          logic [DATA_W-1:0] wdata, logic [DATA_W-1:0] rdval,
                          int low, bit intrude);
    int cycle;
    int cmdCycles;
    bit dirOk;
    bit stableOk;
    logic [MEM_ADDR_W-1:0] ea;
    ea = expAddr(io, addr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqIo = io; reqAddr = addr; reqWdata = wdata;
    tgtLow = low; busRdata = rdval;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    // address cycle
    check(busAle && busy && !busRd && !busWr, "R2 ale", busAle, 1);
    check(busAddr == ea, "R3 addr", busAddr, ea);
    check(busMemSel == !io, "R3 memsel", busMemSel, !io);
    cycle = 1; cmdCycles = 0; dirOk = 1; stableOk = 1;
    while (!done && cycle < 40) begin
      @(negedge clk);
      cycle++;
      if (cycle == 2) check(busRd || busWr, "R2 cmd after ale", busRd || busWr, 1);
      if (busAle) dirOk = 0;
      if (busRd || busWr) begin
        cmdCycles++;
        if (busRd == wr || busWr != wr) dirOk = 0;
      end
      if (busAddr != ea || busWdata != wdata || !busy) stableOk = 0;
      if (intrude && cycle == 2) begin
        reqValid = 1'b1; reqAddr = ~addr; reqIo = !io;
      end
      if (intrude && cycle == 3) reqValid = 1'b0;
    end
    check(dirOk, "R8 direction", dirOk, 1);
    check(stableOk, intrude ? "R9 ignored while busy" : "R8 stable", stableOk, 1);
    check(cycle == 4 + expWaits(low), low == 0 ? "R4 latency" : "R5 latency",
          cycle, 4 + expWaits(low));
    check(cmdCycles == 2 + expWaits(low), "R5 command length", cmdCycles, 2 + expWaits(low));
    check(timeout == expTimeout(low), "R6 timeout", timeout, expTimeout(low));
    check(!busRd && !busWr, "R10 no cmd at done", busRd || busWr, 0);
    if (!wr) lastRead = rdval;
    check(rdData == lastRead, "R7 read data", rdData, lastRead);
    @(negedge clk);
    check(!done && !busy, "R10 done pulse / R9 busy clear", {done, busy}, 0);
    check(!busAle && !busRd && !busWr, "R9 no new cycle", {busAle, busRd, busWr}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !timeout && !busAle && !busRd && !busWr, "R1 reset",
          {busy, done, timeout, busAle, busRd, busWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !busAle, "R1 idle after reset", {busy, busAle}, 0);

    // directed corners
    runCycle(0, 0, 20'hFFFFF, 16'h0000, 16'hA55A, 0, 0);  // R4 fast memory read
    runCycle(1, 1, 20'hF1234, 16'hBEEF, 16'h1111, 3, 0);  // R3 I/O write, R5 waits
    runCycle(0, 1, 20'hABCDE, 16'h0000, 16'h5A5A, 6, 0);  // R6 exactly at ceiling
    runCycle(0, 0, 20'h00001, 16'h0000, 16'hC3C3, 7, 0);  // R6 timeout
    runCycle(1, 0, 20'h12345, 16'h7777, 16'h9999, 9, 0);  // R6 write timeout, R7 kept
    runCycle(0, 0, 20'h2AAAA, 16'h0000, 16'h0F0F, 1, 1);  // R9 intrusion

    for (int i = 0; i < 40; i++) begin
      runCycle(1'($urandom), 1'($urandom), MEM_ADDR_W'($urandom),
               DATA_W'($urandom), DATA_W'($urandom), int'($urandom % 10), 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule